// File: doc/BRIEF.md
# Vector Floating-Point Precision Converter

This unit changes the precision of the floating-point lanes held in a 128-bit vector register. It supports half, single and double precision. Widening reads one half of the first operand, picked by a half-select input, and returns lanes twice as wide. Narrowing reads both operands and packs all of their lanes into one result of half-width lanes. Narrowing rounds to nearest, with ties going to even. NaN, infinity, signed zero and subnormal values are all converted.

The unit is a plain three-stage pipeline with no back-pressure. It takes one operation per cycle, marked by `valid_i`. Exactly three clock edges later the converted vector appears on `res_o`, and `valid_o` is high for that cycle. Lane `k` of width `w` always occupies bits `[w*k +: w]`.

Top module: `fpcvt_unit`

## Requirements
- R1: With op code 2'b00, each single lane of the selected half of `opa_i` widens exactly to a double in result lanes 0–1. With `hi_sel_i`=0 the sources are single lanes 0–1, and with `hi_sel_i`=1 they are lanes 2–3. Single subnormals become normalised doubles.
- R2: With op code 2'b01, each half lane of the selected half of `opa_i` widens exactly to a single in result lanes 0–3. With `hi_sel_i`=0 the sources are half lanes 0–3, and with `hi_sel_i`=1 they are lanes 4–7. Half subnormals become normalised singles.
- R3: With op code 2'b10, the two double lanes of `opb_i` narrow to result single lanes 0–1 and the two double lanes of `opa_i` narrow to lanes 2–3. Rounding is to nearest, ties to even. A result too large for single becomes a signed infinity. A result below the normal range becomes a correctly rounded subnormal or a signed zero.
- R4: With op code 2'b11, the four single lanes of `opb_i` narrow to result half lanes 0–3 and the four single lanes of `opa_i` narrow to lanes 4–7. Rounding, overflow and underflow behave as in R3.
- R5: A NaN input gives a NaN output with the same sign and an all-ones exponent. The output mantissa has its top bit set. Its remaining bits are the input mantissa bits below the top bit, truncated when narrowing and padded with zeros when widening. An infinity or a zero keeps its sign.
- R6: Every operation issued with `valid_i` high returns on `res_o` with `valid_o` high exactly 3 cycles later. One operation can be issued on every cycle.
- R7: After reset `valid_o` and `res_o` are zero. While `valid_o` is low, `res_o` holds its last value.
- R8: Narrowing ignores `hi_sel_i` and widening ignores `opb_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| valid_i | input | 1 | Operation issue strobe |
| op_i | input | 2 | Conversion code (R1–R4) |
| hi_sel_i | input | 1 | Half select for widening |
| opa_i | input | 128 | First operand |
| opb_i | input | 128 | Second operand, used by narrowing only |
| valid_o | output | 1 | Result strobe, 3 cycles after issue |
| res_o | output | 128 | Converted vector |

## Verification
The bench builds the unit with its default 128-bit vector width. At that width every one of the 65536 half encodings can be streamed through the half-to-single widening path in both half positions. The single and double paths are swept over every biased exponent that matters for the target format, combined with mantissa patterns chosen to hit exact ties, near ties, all-ones carries and NaN payloads. That reaches the overflow edge, the subnormal boundary and the round-to-zero edge of every path.

// File: rtl/fpcvt_pkg.sv
package fpcvt_pkg;
  typedef enum logic [1:0] {
    OP_S2D = 2'b00,
    OP_H2S = 2'b01,
    OP_D2S = 2'b10,
    OP_S2H = 2'b11
  } cvt_op_e;

  localparam int HALF_E = 5;
  localparam int HALF_M = 10;
  localparam int SGL_E  = 8;
  localparam int SGL_M  = 23;
  localparam int DBL_E  = 11;
  localparam int DBL_M  = 52;

  localparam int HALF_W = 1 + HALF_E + HALF_M;
  localparam int SGL_W  = 1 + SGL_E + SGL_M;
  localparam int DBL_W  = 1 + DBL_E + DBL_M;
endpackage

// File: rtl/fpcvt_stage.sv
module fpcvt_stage #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (en_i) q_o <= d_i;
  end
endmodule

// File: rtl/fpcvt_widen.sv
module fpcvt_widen #(
  parameter int EI = 8,
  parameter int MI = 23,
  parameter int EO = 11,
  parameter int MO = 52
) (
  input  logic [EI+MI:0] in_i,
  output logic [EO+MO:0] out_o
);
  localparam int BI  = 2**(EI-1) - 1;
  localparam int BO  = 2**(EO-1) - 1;
  localparam int PAD = MO - MI;

  logic          sgn;
  logic [EI-1:0] exp_in;
  logic [MI-1:0] man_in;
  logic [MI-1:0] man_norm;
  int            msb_pos;
  int            shift;

  assign sgn    = in_i[EI+MI];
  assign exp_in = in_i[EI+MI-1:MI];
  assign man_in = in_i[MI-1:0];

  // highest set mantissa bit for subnormal normalisation
  always_comb begin
    msb_pos = 0;
    for (int k = 0; k < MI; k++) begin
      if (man_in[k]) msb_pos = k;
    end
    shift    = MI - msb_pos;
    man_norm = man_in << shift;
  end

  always_comb begin
    if (exp_in == '1) begin
      if (man_in == '0) out_o = {sgn, {EO{1'b1}}, {MO{1'b0}}};
      else              out_o = {sgn, {EO{1'b1}}, 1'b1, man_in[MI-2:0], {PAD{1'b0}}};
    end else if (exp_in == '0) begin
      if (man_in == '0) out_o = {sgn, {(EO+MO){1'b0}}};
      else              out_o = {sgn, EO'(BO - BI + 1 - shift), man_norm, {PAD{1'b0}}};
    end else begin
      out_o = {sgn, EO'(int'(exp_in) - BI + BO), man_in, {PAD{1'b0}}};
    end
  end
endmodule

// File: rtl/fpcvt_narrow.sv
module fpcvt_narrow #(
  parameter int EI = 11,
  parameter int MI = 52,
  parameter int EO = 8,
  parameter int MO = 23
) (
  input  logic [EI+MI:0] in_i,
  output logic [EO+MO:0] out_o
);
  localparam int BI   = 2**(EI-1) - 1;
  localparam int BO   = 2**(EO-1) - 1;
  localparam int EMAX = 2**EO - 1;
  localparam int WS   = MI + 1;
  localparam int DROP = MI - MO;

  logic          sgn;
  logic [EI-1:0] exp_in;
  logic [MI-1:0] man_in;
  int            te;
  int            sh;
  logic [2*WS:0] tmp;
  logic [MO:0]   kept;
  logic          guard;
  logic          sticky;
  logic          up;
  logic [EO-1:0] exp_f;
  logic [EO+MO-1:0] mag;

  assign sgn    = in_i[EI+MI];
  assign exp_in = in_i[EI+MI-1:MI];
  assign man_in = in_i[MI-1:0];
  assign te     = int'(exp_in) - BI + BO;

  // right shift with guard and sticky; the hidden bit carries into the exponent field
  always_comb begin
    sh = (te >= 1) ? DROP : DROP + 1 - te;
    if (sh > WS + 1) sh = WS + 1;
    tmp    = {1'b1, man_in, {(WS+1){1'b0}}} >> sh;
    kept   = tmp[WS+MO+1:WS+1];
    guard  = tmp[WS];
    sticky = |tmp[WS-1:0];
    up     = guard & (sticky | kept[0]);
    exp_f  = (te >= 1) ? EO'(te - 1) : '0;
    mag    = {exp_f, {MO{1'b0}}} + {{(EO-1){1'b0}}, kept} + {{(EO+MO-1){1'b0}}, up};
  end

  always_comb begin
    if (exp_in == '1) begin
      if (man_in == '0) out_o = {sgn, {EO{1'b1}}, {MO{1'b0}}};
      else              out_o = {sgn, {EO{1'b1}}, 1'b1, man_in[MI-2 -: MO-1]};
    end else if (exp_in == '0) begin
      out_o = {sgn, {(EO+MO){1'b0}}};
    end else if (te >= EMAX) begin
      out_o = {sgn, {EO{1'b1}}, {MO{1'b0}}};
    end else begin
      out_o = {sgn, mag};
    end
  end
endmodule

// File: rtl/fpcvt_unit.sv
module fpcvt_unit
  import fpcvt_pkg::*;
#(
  parameter int VEC_W = 128
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             valid_i,
  input  logic [1:0]       op_i,
  input  logic             hi_sel_i,
  input  logic [VEC_W-1:0] opa_i,
  input  logic [VEC_W-1:0] opb_i,
  output logic             valid_o,
  output logic [VEC_W-1:0] res_o
);
  localparam int HV  = VEC_W / 2;
  localparam int N_D = VEC_W / DBL_W;
  localparam int N_S = VEC_W / SGL_W;
  localparam int N_H = VEC_W / HALF_W;

  // stage 1: capture
  logic             v1, v2;
  logic [1:0]       op1_raw;
  logic             hi1;
  logic [VEC_W-1:0] a1, b1;
  cvt_op_e          op1;

  fpcvt_stage #(.W(1)) u_v1 (.clk_i, .rst_ni, .en_i(1'b1), .d_i(valid_i), .q_o(v1));
  fpcvt_stage #(.W(2*VEC_W+3)) u_d1 (
    .clk_i, .rst_ni, .en_i(valid_i),
    .d_i({op_i, hi_sel_i, opa_i, opb_i}),
    .q_o({op1_raw, hi1, a1, b1})
  );
  assign op1 = cvt_op_e'(op1_raw);

  // stage 2: lane select and convert
  logic [HV-1:0]      half_src;
  logic [2*VEC_W-1:0] pair_src;
  logic [VEC_W-1:0]   w_sd, w_hs, n_ds, n_sh, r2;

  assign half_src = hi1 ? a1[VEC_W-1:HV] : a1[HV-1:0];
  assign pair_src = {a1, b1};

  for (genvar i = 0; i < N_D; i++) begin : g_s2d
    fpcvt_widen #(.EI(SGL_E), .MI(SGL_M), .EO(DBL_E), .MO(DBL_M)) u_cvt (
      .in_i(half_src[SGL_W*i +: SGL_W]), .out_o(w_sd[DBL_W*i +: DBL_W]));
  end
  for (genvar i = 0; i < N_S; i++) begin : g_h2s
    fpcvt_widen #(.EI(HALF_E), .MI(HALF_M), .EO(SGL_E), .MO(SGL_M)) u_cvt (
      .in_i(half_src[HALF_W*i +: HALF_W]), .out_o(w_hs[SGL_W*i +: SGL_W]));
  end
  for (genvar i = 0; i < N_S; i++) begin : g_d2s
    fpcvt_narrow #(.EI(DBL_E), .MI(DBL_M), .EO(SGL_E), .MO(SGL_M)) u_cvt (
      .in_i(pair_src[DBL_W*i +: DBL_W]), .out_o(n_ds[SGL_W*i +: SGL_W]));
  end
  for (genvar i = 0; i < N_H; i++) begin : g_s2h
    fpcvt_narrow #(.EI(SGL_E), .MI(SGL_M), .EO(HALF_E), .MO(HALF_M)) u_cvt (
      .in_i(pair_src[SGL_W*i +: SGL_W]), .out_o(n_sh[HALF_W*i +: HALF_W]));
  end

  always_comb begin
    case (op1)
      OP_S2D:  r2 = w_sd;
      OP_H2S:  r2 = w_hs;
      OP_D2S:  r2 = n_ds;
      default: r2 = n_sh;
    endcase
  end

  logic [VEC_W-1:0] r2_q;
  fpcvt_stage #(.W(1))     u_v2 (.clk_i, .rst_ni, .en_i(1'b1), .d_i(v1), .q_o(v2));
  fpcvt_stage #(.W(VEC_W)) u_d2 (.clk_i, .rst_ni, .en_i(v1), .d_i(r2), .q_o(r2_q));

  // stage 3: output
  fpcvt_stage #(.W(1))     u_v3 (.clk_i, .rst_ni, .en_i(1'b1), .d_i(v2), .q_o(valid_o));
  fpcvt_stage #(.W(VEC_W)) u_d3 (.clk_i, .rst_ni, .en_i(v2), .d_i(r2_q), .q_o(res_o));

  // checks
  logic [1:0]         warm_q;
  logic [2*VEC_W-1:0] pair_in;
  logic [N_H-1:0]     s_nan_in;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              warm_q <= '0;
    else if (warm_q != 2'd3)  warm_q <= warm_q + 2'd1;
  end

  assign pair_in = {opa_i, opb_i};
  for (genvar i = 0; i < N_H; i++) begin : g_nan_in
    assign s_nan_in[i] = (pair_in[SGL_W*i+SGL_M +: SGL_E] == '1) &&
                         (pair_in[SGL_W*i +: SGL_M] != '0);
  end

  assert_latency_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q == 2'd3) |-> (valid_o == $past(valid_i, 3)));

  assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(res_o));

  for (genvar i = 0; i < N_H; i++) begin : g_chk_nan
    assert_nan_quiet_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (warm_q == 2'd3 && valid_o && $past(op_i, 3) == OP_S2H && $past(s_nan_in[i], 3))
      |-> (res_o[HALF_W*i+HALF_M +: HALF_E] == '1 && res_o[HALF_W*i+HALF_M-1]));
  end

  for (genvar i = 0; i < N_S; i++) begin : g_chk_sign
    assert_sign_kept_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (warm_q == 2'd3 && valid_o && $past(op_i, 3) == OP_D2S)
      |-> (res_o[SGL_W*i+SGL_W-1] == $past(pair_in[DBL_W*i+DBL_W-1], 3)));
  end
endmodule

// File: tb/fpcvt_unit_tb_top.sv
`timescale 1ns/1ps
module fpcvt_unit_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         valid_i = 1'b0;
  logic [1:0]   op_i = '0;
  logic         hi_sel_i = 1'b0;
  logic [127:0] opa_i = '0;
  logic [127:0] opb_i = '0;
  logic         valid_o;
  logic [127:0] res_o;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit started = 1'b0;
  bit done    = 1'b0;
  logic [127:0] last_res = '0;

  logic [127:0] exp_q[$];
  string        tag_q[$];
  int           cyc_q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc++;

  fpcvt_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid_i), .op_i(op_i), .hi_sel_i(hi_sel_i),
    .opa_i(opa_i), .opb_i(opb_i), .valid_o(valid_o), .res_o(res_o)
  );

  function automatic real pow2(int k);
    real r = 1.0;
    if (k >= 0) repeat (k) r = r * 2.0;
    else        repeat (-k) r = r / 2.0;
    return r;
  endfunction

  function automatic longint rne(real q);
    real    fl = $floor(q);
    real    d  = q - fl;
    longint n  = longint'(fl);
    if (d > 0.5 || (d == 0.5 && n[0])) n++;
    return n;
  endfunction

  function automatic real dec(longint e, longint m, int ew, int mw);
    longint bias = (64'sd1 <<< (ew-1)) - 1;
    if (e == 0) return real'(m) * pow2(int'(1 - bias - mw));
    return (real'(m) + pow2(mw)) * pow2(int'(e - bias - mw));
  endfunction

  function automatic logic [63:0] enc(bit s, real a, int ew, int mw);
    longint      bias = (64'sd1 <<< (ew-1)) - 1;
    real         mn = a;
    longint      e = 0;
    longint      n;
    logic [63:0] r = '0;
    logic [63:0] inf = ((64'd1 << ew) - 1) << mw;
    if (a != 0.0) begin
      while (mn >= 2.0) begin mn = mn / 2.0; e++; end
      while (mn < 1.0)  begin mn = mn * 2.0; e--; end
      if (e > bias) r = inf;
      else if (e < 1 - bias) begin
        n = rne(mn * pow2(int'(e + bias - 1 + mw)));
        r = 64'(n);
      end else begin
        n = rne(mn * pow2(mw));
        if (n == (64'sd1 <<< (mw+1))) begin n = n / 2; e++; end
        if (e > bias) r = inf;
        else r = (64'(e + bias) << mw) | 64'(n - (64'sd1 <<< mw));
      end
    end
    r[ew+mw] = s;
    return r;
  endfunction

  function automatic logic [63:0] conv(logic [63:0] x, int ei, int mi, int eo, int mo);
    longint      emi = (64'sd1 <<< ei) - 1;
    bit          s = x[ei+mi];
    longint      e = longint'((x >> mi) & 64'(emi));
    longint      m = longint'(x & ((64'd1 << mi) - 1));
    longint      om;
    logic [63:0] r;
    if (e == emi) begin
      if (m == 0) om = 0;
      else if (mo > mi) om = ((64'sd1 <<< (mi-1)) | (m & ((64'sd1 <<< (mi-1)) - 1))) <<< (mo-mi);
      else om = (m >>> (mi-mo)) | (64'sd1 <<< (mo-1));
      r = (((64'd1 << eo) - 1) << mo) | 64'(om);
      r[eo+mo] = s;
      return r;
    end
    return enc(s, dec(e, m, ei, mi), eo, mo);
  endfunction

  function automatic logic [127:0] vec_expect(logic [1:0] op, logic hi, logic [127:0] a, logic [127:0] b);
    logic [127:0] o = '0;
    logic [255:0] pr = {a, b};
    logic [63:0]  h  = hi ? a[127:64] : a[63:0];
    logic [63:0]  t;
    case (op)
      2'b00: for (int i = 0; i < 2; i++) o[64*i +: 64] = conv({32'b0, h[32*i +: 32]}, 8, 23, 11, 52);
      2'b01: for (int i = 0; i < 4; i++) begin
        t = conv({48'b0, h[16*i +: 16]}, 5, 10, 8, 23); o[32*i +: 32] = t[31:0];
      end
      2'b10: for (int i = 0; i < 4; i++) begin
        t = conv(pr[64*i +: 64], 11, 52, 8, 23); o[32*i +: 32] = t[31:0];
      end
      default: for (int i = 0; i < 8; i++) begin
        t = conv({32'b0, pr[32*i +: 32]}, 8, 23, 5, 10); o[16*i +: 16] = t[15:0];
      end
    endcase
    return o;
  endfunction

  function automatic logic [31:0] fgen(int j);
    logic [22:0] mp [16] = '{23'h0, 23'h1, 23'h1000, 23'h3000, 23'h0FFF, 23'h1001, 23'h2000,
                             23'h7FFFFF, 23'h400000, 23'h400001, 23'h1FFF, 23'h7FF000,
                             23'h7FE000, 23'h7FF001, 23'h800, 23'h200000};
    return {j[0], 8'(j >> 5), mp[(j >> 1) % 16]};
  endfunction

  function automatic logic [63:0] dgen(int j);
    logic [51:0] mp [8] = '{52'h0, 52'h1, 52'h10000000, 52'h30000000, 52'h0FFFFFFF,
                            52'h10000001, 52'hFFFFFFFFFFFFF, 52'h8000000000000};
    int ei = j >> 4;
    logic [10:0] e = (ei == 302) ? 11'd0 : (ei == 303) ? 11'h7FF : 11'(868 + ei);
    return {j[0], e, mp[(j >> 1) % 8]};
  endfunction

  task automatic issue(logic [1:0] op, logic hi, logic [127:0] a, logic [127:0] b, string tag);
    @(negedge clk);
    valid_i = 1'b1; op_i = op; hi_sel_i = hi; opa_i = a; opb_i = b;
    exp_q.push_back(vec_expect(op, hi, a, b));
    tag_q.push_back(tag);
    cyc_q.push_back(cyc);
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      valid_i = 1'b0; opa_i = {4{$urandom}}; opb_i = {4{$urandom}}; op_i = 2'($urandom);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(negedge clk) begin
    if (started && !done) begin
      if (valid_o) begin
        logic [127:0] ex;
        string        tg;
        int           c0;
        checks++;
        if (exp_q.size() == 0) begin
          fails++;
          $display("FAIL R6: unexpected valid_o, got 1 expected 0");
        end else begin
          ex = exp_q.pop_front(); tg = tag_q.pop_front(); c0 = cyc_q.pop_front();
          if (res_o !== ex) begin
            fails++;
            $display("FAIL %s: got %h expected %h", tg, res_o, ex);
          end
          checks++;
          if (cyc - c0 != 3) begin
            fails++;
            $display("FAIL R6: latency got %0d expected 3", cyc - c0);
          end
        end
        last_res = res_o;
      end else begin
        checks++;
        if (res_o !== last_res) begin
          fails++;
          $display("FAIL R7: idle result got %h expected %h", res_o, last_res);
        end
      end
    end
  end

  initial begin
    repeat (120000) @(posedge clk);
    done = 1'b1;
    fails++;
    $display("FAIL R6: watchdog expired, got hang expected completion");
    report();
  end

  initial begin
    logic [127:0] a, b;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    checks++;
    if (valid_o !== 1'b0 || res_o !== '0) begin
      fails++;
      $display("FAIL R7: reset state got %b/%h expected 0/0", valid_o, res_o);
    end
    started = 1'b1;

    // R2, R5, R8: every half encoding, low and high halves, random opb
    for (int v = 0; v < 8192; v++) begin
      for (int k = 0; k < 8; k++) a[16*k +: 16] = 16'(8*v + k);
      issue(2'b01, 1'b0, a, {4{$urandom}}, "R2");
      issue(2'b01, 1'b1, a, {4{$urandom}}, "R2");
      if (v % 977 == 0) idle(2);
    end

    // R1, R8: single to double
    for (int v = 0; v < 2048; v++) begin
      for (int k = 0; k < 4; k++) a[32*k +: 32] = fgen(4*v + k);
      issue(2'b00, v[0], a, {4{$urandom}}, "R1");
      if (v % 311 == 0) idle(1);
    end

    // R4, R5, R8: single to half, hi_sel toggled
    for (int v = 0; v < 1024; v++) begin
      for (int k = 0; k < 4; k++) begin
        b[32*k +: 32] = fgen(8*v + k);
        a[32*k +: 32] = fgen(8*v + 4 + k);
      end
      issue(2'b11, v[0], a, b, "R4");
      if (v % 97 == 0) issue(2'b11, ~v[0], a, b, "R8");
    end

    // R3, R5: double to single
    for (int v = 0; v < 1216; v++) begin
      for (int k = 0; k < 2; k++) begin
        b[64*k +: 64] = dgen(4*v + k);
        a[64*k +: 64] = dgen(4*v + 2 + k);
      end
      issue(2'b10, v[0], a, b, "R3");
      if (v % 101 == 0) idle(3);
    end

    idle(8);
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R6: outstanding results got %0d expected 0", exp_q.size());
    end
    done = 1'b1;
    report();
  end
endmodule